// File: doc/BRIEF.md
# Base-Index-Displacement Effective Address Unit

This unit turns the operand fields of a decoded instruction into 24-bit storage addresses. The caller presents a two-bit format code and the instruction with its leading operation byte removed, a 40-bit word. In the same cycle the unit drives the register numbers it needs onto two read ports of an external general register file, which answers combinationally. It adds the returned contents to the 12-bit displacement and registers the result. The address appears one cycle after the request, with a one-cycle valid strobe.

The register-indexed format adds a base register, an index register and the displacement. The register-storage and storage-immediate formats add only the base register and the displacement. A register field of zero always stands for a zero term, whatever register 0 holds. The storage-storage format carries two base/displacement pairs and yields two addresses on successive cycles, marked by a tag. During the second of those cycles the unit reports itself busy and drops any new request. For the storage-immediate format the unit also presents the immediate byte alongside the address.

Top module: `ea_gen`

## Requirements
- R1: Format code 0 (register-indexed): the address is term(B)+term(X)+D, where B is req_insn[31:28], X is req_insn[35:32] and D is req_insn[27:16]. It is presented with ea_valid high on the cycle after the request is taken, and ea_second is low.
- R2: Format codes 1 (register-storage) and 2 (storage-immediate): the address is term(B)+D with the same B and D positions. The index field and the read port B data have no effect.
- R3: term(r) is 0 when the 4-bit field r is 0, even when the register file returns a nonzero value for register 0. Otherwise term(r) is the low 24 bits of the register's content.
- R4: The sum is taken modulo 2^24. Register bits above bit 23 and carries out of bit 23 do not affect the address.
- R5: Format code 3 (storage-storage): on the first cycle after acceptance the unit presents term(B1)+D1 with ea_second low (B1=req_insn[31:28], D1=req_insn[27:16]). On the next cycle it presents term(B2)+D2 with ea_second high (B2=req_insn[15:12], D2=req_insn[11:0]).
- R6: ea_imm carries req_insn[39:32] while a storage-immediate address is valid. In every other cycle ea_imm is 0.
- R7: ea_valid is high for exactly one cycle per generated address and low when no address is due. After reset, ea_valid, ea_second and busy are low.
- R8: busy is high for exactly the one cycle in which the second storage-storage address is being produced. A request presented while busy is high is dropped and produces no address.
- R9: In a request cycle, rda_sel equals req_insn[31:28]. rdb_sel equals the index field for format 0, B2 for format 3, and 0 for formats 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_fmt | input | 2 | Format: 0 indexed, 1 register-storage, 2 storage-immediate, 3 storage-storage |
| req_insn | input | 40 | Instruction with the operation byte removed |
| rda_sel | output | 4 | Register number on read port A |
| rda_data | input | 32 | Content returned on read port A |
| rdb_sel | output | 4 | Register number on read port B |
| rdb_data | input | 32 | Content returned on read port B |
| busy | output | 1 | Second storage-storage address in progress; requests dropped |
| ea_valid | output | 1 | Address strobe |
| ea_addr | output | 24 | Generated address |
| ea_second | output | 1 | High when the address is the second storage-storage operand |
| ea_imm | output | 8 | Immediate byte of a storage-immediate request |

## Verification
The hardest case to reach is a request that arrives in the single busy cycle after a storage-storage request. It must leave no trace in the address stream, yet the strobe must still fire for the pending second operand. The stimulus places such requests deliberately, and random traffic keeps valid high on most cycles so that back-to-back collisions recur. A second hard case is a zero register field when register 0 holds a nonzero value. The bench model returns a nonzero value for register 0 to make that case observable.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 24;
  localparam int REG_W  = 32;
  localparam int DISP_W = 12;
  localparam int SEL_W  = 4;
  localparam int IMM_W  = 8;
  localparam int INSN_W = 40;

  typedef enum logic [1:0] {
    FMT_RX = 2'd0,
    FMT_RS = 2'd1,
    FMT_SI = 2'd2,
    FMT_SS = 2'd3
  } ea_fmt_e;

  typedef struct packed {
    logic [SEL_W-1:0]  b1;
    logic [SEL_W-1:0]  xr;
    logic [SEL_W-1:0]  b2;
    logic [DISP_W-1:0] d1;
    logic [DISP_W-1:0] d2;
    logic [IMM_W-1:0]  imm;
  } ea_fields_t;
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split
  import ea_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  ea_fmt_e           fmt,
  output ea_fields_t        fld,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b
);
  localparam int IMM_LSB = INSN_W - IMM_W;
  localparam int XR_LSB  = IMM_LSB;
  localparam int B1_LSB  = IMM_LSB - SEL_W;
  localparam int D1_LSB  = B1_LSB - DISP_W;
  localparam int B2_LSB  = D1_LSB - SEL_W;
  localparam int D2_LSB  = B2_LSB - DISP_W;

  always_comb begin
    fld.imm = insn[IMM_LSB +: IMM_W];
    fld.xr  = insn[XR_LSB  +: SEL_W];
    fld.b1  = insn[B1_LSB  +: SEL_W];
    fld.d1  = insn[D1_LSB  +: DISP_W];
    fld.b2  = insn[B2_LSB  +: SEL_W];
    fld.d2  = insn[D2_LSB  +: DISP_W];
  end

  assign sel_a = fld.b1;

  always_comb begin
    unique case (fmt)
      FMT_RX:  sel_b = fld.xr;
      FMT_SS:  sel_b = fld.b2;
      default: sel_b = '0;
    endcase
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc #(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [REG_W-1:0]  base_data,
  input  logic [SEL_W-1:0]  idx_sel,
  input  logic [REG_W-1:0]  idx_data,
  input  logic              idx_en,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] sum
);
  localparam int HI_W = REG_W - ADDR_W;

  function automatic logic [ADDR_W-1:0] reg_term(
    input logic [SEL_W-1:0] sel, input logic [REG_W-1:0] data);
    return (sel == '0) ? '0 : data[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] add3(
    input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
    input logic [DISP_W-1:0] d);
    return a + b + ADDR_W'(d);
  endfunction

  logic [ADDR_W-1:0] base_t, idx_t;
  logic [2*HI_W-1:0] unused_hi;

  assign base_t    = reg_term(base_sel, base_data);
  assign idx_t     = idx_en ? reg_term(idx_sel, idx_data) : '0;
  assign sum       = add3(base_t, idx_t, disp);
  assign unused_hi = {base_data[REG_W-1:ADDR_W], idx_data[REG_W-1:ADDR_W]};
endmodule

// File: rtl/ea_out_seq.sv
module ea_out_seq #(
  parameter int ADDR_W = 24,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              is_si,
  input  logic              is_ss,
  input  logic [ADDR_W-1:0] sum_first,
  input  logic [ADDR_W-1:0] sum_second,
  input  logic [IMM_W-1:0]  imm_in,
  output logic              accept,
  output logic              busy,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_second,
  output logic [IMM_W-1:0]  ea_imm
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr2_q;

  assign accept = req_valid & ~pend_q;
  assign busy   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      addr2_q   <= '0;
      ea_valid  <= 1'b0;
      ea_addr   <= '0;
      ea_second <= 1'b0;
      ea_imm    <= '0;
    end else if (pend_q) begin
      pend_q    <= 1'b0;
      ea_valid  <= 1'b1;
      ea_addr   <= addr2_q;
      ea_second <= 1'b1;
      ea_imm    <= '0;
    end else if (accept) begin
      pend_q    <= is_ss;
      addr2_q   <= sum_second;
      ea_valid  <= 1'b1;
      ea_addr   <= sum_first;
      ea_second <= 1'b0;
      ea_imm    <= is_si ? imm_in : '0;
    end else begin
      ea_valid  <= 1'b0;
      ea_second <= 1'b0;
      ea_imm    <= '0;
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_fmt,
  input  logic [INSN_W-1:0] req_insn,
  output logic [SEL_W-1:0]  rda_sel,
  input  logic [REG_W-1:0]  rda_data,
  output logic [SEL_W-1:0]  rdb_sel,
  input  logic [REG_W-1:0]  rdb_data,
  output logic              busy,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_second,
  output logic [IMM_W-1:0]  ea_imm
);
  localparam int LANES = 2;

  ea_fmt_e           fmt;
  ea_fields_t        fld;
  logic [ADDR_W-1:0] lane_sum [LANES];
  logic              accept_w;
  logic              fmt_is_rx, fmt_is_si, fmt_is_ss;

  assign fmt       = ea_fmt_e'(req_fmt);
  assign fmt_is_rx = (fmt == FMT_RX);
  assign fmt_is_si = (fmt == FMT_SI);
  assign fmt_is_ss = (fmt == FMT_SS);

  ea_field_split i_split (
    .insn  (req_insn),
    .fmt   (fmt),
    .fld   (fld),
    .sel_a (rda_sel),
    .sel_b (rdb_sel)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    ea_addr_calc #(
      .ADDR_W (ADDR_W), .REG_W (REG_W), .DISP_W (DISP_W), .SEL_W (SEL_W)
    ) i_calc (
      .base_sel  (ln == 0 ? rda_sel  : rdb_sel),
      .base_data (ln == 0 ? rda_data : rdb_data),
      .idx_sel   (ln == 0 ? rdb_sel  : rda_sel),
      .idx_data  (ln == 0 ? rdb_data : rda_data),
      .idx_en    (ln == 0 ? fmt_is_rx : 1'b0),
      .disp      (ln == 0 ? fld.d1   : fld.d2),
      .sum       (lane_sum[ln])
    );
  end

  ea_out_seq #(.ADDR_W (ADDR_W), .IMM_W (IMM_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .is_si      (fmt_is_si),
    .is_ss      (fmt_is_ss),
    .sum_first  (lane_sum[0]),
    .sum_second (lane_sum[1]),
    .imm_in     (fld.imm),
    .accept     (accept_w),
    .busy       (busy),
    .ea_valid   (ea_valid),
    .ea_addr    (ea_addr),
    .ea_second  (ea_second),
    .ea_imm     (ea_imm)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic [1:0] req_fmt,
  input logic       busy,
  input logic       ea_valid,
  input logic       ea_second,
  input logic [7:0] ea_imm
);
  // R7: every strobe has a cause one cycle earlier
  a_r7_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> ($past(accept) || $past(busy)));

  // R7: no cause means no strobe
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(accept) && !$past(busy)) |-> !ea_valid);

  // R8: busy lasts one cycle
  a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R5: busy cycle yields the tagged second address
  a_r5_busy_brings_second: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ea_valid && ea_second));

  // R5: the tag only follows a busy cycle
  a_r5_second_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ea_second) |-> $past(busy));

  // R6: non-immediate requests carry a zero byte
  a_r6_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_fmt != 2'd2) |=> (ea_imm == 8'd0));
endmodule

bind ea_gen ea_gen_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept_w),
  .req_fmt   (req_fmt),
  .busy      (busy),
  .ea_valid  (ea_valid),
  .ea_second (ea_second),
  .ea_imm    (ea_imm)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_fmt = 2'd0;
  logic [39:0] req_insn = '0;
  logic [3:0]  rda_sel, rdb_sel;
  logic [31:0] rda_data, rdb_data;
  logic        busy, ea_valid, ea_second;
  logic [23:0] ea_addr;
  logic [7:0]  ea_imm;

  logic [31:0] gpr [16];
  int n_chk = 0;
  int n_fail = 0;
  string focus = "";

  // model state
  bit          m_pend = 0;
  int unsigned m_addr2 = 0;
  bit          x_valid = 0;
  int unsigned x_addr = 0;
  bit          x_second = 0;
  int unsigned x_imm = 0;

  always #2.5 clk = ~clk;

  assign rda_data = gpr[rda_sel];
  assign rdb_data = gpr[rdb_sel];

  ea_gen i_ea_gen (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_fmt (req_fmt),
    .req_insn (req_insn), .rda_sel (rda_sel), .rda_data (rda_data),
    .rdb_sel (rdb_sel), .rdb_data (rdb_data), .busy (busy),
    .ea_valid (ea_valid), .ea_addr (ea_addr), .ea_second (ea_second),
    .ea_imm (ea_imm)
  );

  function automatic void check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic string pick(string dflt);
    return (focus != "") ? focus : dflt;
  endfunction

  function automatic longint term(int r);
    return (r == 0) ? 0 : longint'(gpr[r] % 32'h0100_0000);
  endfunction

  function automatic logic [39:0] mk(int hi8, int b1, int d1, int lo16);
    return {hi8[7:0], b1[3:0], d1[11:0], lo16[15:0]};
  endfunction

  task automatic step(bit v, int f, logic [39:0] insn);
    int b1, xr, d1, b2, d2, imm;
    longint a1, a2;
    string atag;
    req_valid = v;
    req_fmt   = f[1:0];
    req_insn  = insn;
    imm = int'(insn / 40'h1_0000_0000);
    xr  = imm % 16;
    b1  = int'((insn / 40'h1000_0000) % 16);
    d1  = int'((insn / 40'h1_0000) % 4096);
    b2  = int'((insn / 40'h1000) % 16);
    d2  = int'(insn % 4096);
    #1;
    check("R8 busy", busy, m_pend);
    if (v && !m_pend) begin
      check(pick("R9 port A"), rda_sel, b1);
      check(pick("R9 port B"), rdb_sel, (f == 0) ? xr : (f == 3) ? b2 : 0);
    end
    a1 = (term(b1) + ((f == 0) ? term(xr) : 0) + d1) % 64'h100_0000;
    a2 = (term(b2) + d2) % 64'h100_0000;
    if (m_pend) begin
      x_valid = 1; x_addr = m_addr2; x_second = 1; x_imm = 0; m_pend = 0;
      atag = "R5 second";
    end else if (v) begin
      x_valid = 1; x_addr = int'(a1); x_second = 0;
      x_imm = (f == 2) ? imm : 0;
      m_pend = (f == 3); m_addr2 = int'(a2);
      atag = (f == 0) ? "R1" : (f == 3) ? "R5 first" : "R2";
    end else begin
      x_valid = 0; x_second = 0; x_imm = 0;
      atag = "R7";
    end
    @(posedge clk);
    @(negedge clk);
    check(pick("R7 valid"), ea_valid, x_valid);
    check(pick("R6 imm"), ea_imm, x_imm);
    if (x_valid) begin
      check(pick(atag), ea_addr, x_addr);
      check(pick("R5 tag"), ea_second, x_second);
    end
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) gpr[i] = 32'h1000 * i + 32'h10;
    gpr[0] = 32'h00AB_CDEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7 reset state
    check("R7 reset valid", ea_valid, 0);
    check("R7 reset second", ea_second, 0);
    check("R8 reset busy", busy, 0);
    @(negedge clk);

    // R1 base + index + displacement
    step(1, 0, mk(8'h35, 5, 12'h010, 16'hFFFF));
    step(0, 0, '0);
    // R3 zero fields ignore register 0 content
    focus = "R3";
    step(1, 0, mk(8'h20, 0, 12'h123, 0));
    step(1, 0, mk(8'h00, 0, 12'hFFF, 0));
    step(1, 3, mk(8'h00, 0, 12'h004, {4'd0, 12'h008}));
    step(0, 0, '0);
    focus = "";
    // R2 index field and port B ignored for RS / SI
    step(1, 1, mk(8'h7C, 5, 12'h010, 16'h9ABC));
    // R6 immediate byte
    step(1, 2, mk(8'h40, 5, 12'h004, 16'h1234));
    step(1, 2, mk(8'hE7, 0, 12'h3FF, 16'h0));
    // R5 storage-storage pair, then R8 request during busy dropped
    step(1, 3, mk(8'h4F, 5, 12'h020, {4'd5, 12'h12C}));
    focus = "R8 dropped";
    step(1, 0, mk(8'h12, 3, 12'h777, 0));
    step(0, 0, '0);
    focus = "";
    // R4 wrap modulo 2^24 with high register bits set
    gpr[9] = 32'hFFFF_FFF0; gpr[10] = 32'h7EFF_FFFF;
    focus = "R4";
    step(1, 0, mk(8'h0A, 9, 12'hFFF, 0));
    step(1, 3, mk(8'h00, 10, 12'h800, {4'd9, 12'h020}));
    step(0, 0, '0);
    focus = "";

    // random traffic, mostly busy
    for (int i = 0; i < 16; i++) gpr[i] = $urandom;
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 8) != 0, $urandom % 4, {$urandom, 8'($urandom)});
      if (n % 97 == 0) gpr[$urandom % 16] = $urandom;
    end
    step(0, 0, '0);
    step(0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule